// File: doc/BRIEF.md
# Frame-Aligned Serial Sample Receiver

This block rebuilds parallel samples from four serial lanes. Each lane carries one 12-bit word per sample period, most significant bit first. The block runs in the bit-rate clock domain. On every rising edge of `clk_i` it takes one bit from each lane and one level of the frame indicator. Word boundaries come only from the frame indicator. A bit sampled while the frame level is high, when it was low in the previous bit period, is the first bit of a new word.

The block checks the spacing between frame edges, so it can tell when alignment is lost. A train of correctly spaced edges sets a lock status. A misplaced edge or a silent frame line clears it. Words reach the output only while the block is locked, and all four lanes are delivered together with a single strobe. The incoming words are offset binary. A mode input can flip the top bit so that the output is two's complement.

Top module: `sample_rx`

## Requirements
- R1: Each lane delivers one bit per `clk_i` rising edge, most significant bit first. The first bit of a word is the one sampled when `frame_i` is 1 and was 0 at the previous edge. The 12 bits from that edge onward form the word.
- R2: When the 12th bit of a word is sampled, `valid_o` is high for exactly the next cycle. During that cycle, `data_o[12n+11:12n]` holds lane n's word for n = 0..3.
- R3: `data_o` changes only in a cycle where `valid_o` is high. Otherwise it holds its last value.
- R4: With `tcomp_i` = 1, bit 11 of every output word is inverted, which turns offset binary into two's complement. With `tcomp_i` = 0, words pass unchanged. The mode is taken in the cycle in which the 12th bit is sampled.
- R5: While tracking, a frame edge whose spacing from the previous edge is not 12 bits does four things. It pulses `align_err_o` for one cycle, starting the cycle after the edge. It drops `locked_o` in that same cycle. It discards the partial word. It restarts capture with that edge's bit as the new first bit.
- R6: `locked_o` rises in the cycle after the 4th consecutive correctly spaced edge, which is the 5th edge of a train. The first edge after reset, after an error or after a timeout serves only as a spacing reference.
- R7: If 24 bit periods pass with no frame edge, `locked_o` drops after the 24th edge-free bit. No error is flagged. The next edge is a new reference.
- R8: `valid_o` is never high while `locked_o` is low. Words that start before the locking edge are not output. A word that runs longer than 12 bits while locked still delivers its first 12 bits.
- R9: While `rst_ni` is low, all outputs are 0 and all shift registers, counters and status flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock, one bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_i | input | 4 | One serial bit per lane |
| frame_i | input | 1 | Frame indicator level |
| tcomp_i | input | 1 | 1 selects two's complement output |
| data_o | output | 48 | Four words, lane n at bits 12n+11:12n |
| valid_o | output | 1 | One-cycle strobe for a new set of words |
| locked_o | output | 1 | Frame alignment established |
| align_err_o | output | 1 | One-cycle pulse on a misplaced frame edge |

## Verification
A word whose first bit is sampled at edge p is due on `valid_o` and `data_o` in the cycle after edge p+11. The bench drives bits on falling edges and compares results one time unit after each rising edge. For each expected word, the driver queues the formatted value before the word's first bit. The monitor pops an entry on every strobe and treats any strobe with an empty queue as a failure.

Lock and error state settle one cycle after the deciding edge. The bench checks them only when the driver task returns, which is half a cycle before the last driven bit is sampled. The edge counts for these checks are worked out from R5 to R7: for example, a timeout lands 24 edges after the last frame edge, and this shows up as the 14th idle bit.

// File: rtl/sample_rx_pkg.sv
package sample_rx_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned WORD_W_DEF = 12;

  typedef enum logic [0:0] {
    TRK_IDLE = 1'b0,
    TRK_RUN  = 1'b1
  } trk_state_e;
endpackage

// File: rtl/sample_rx_frame_trk.sv
module sample_rx_frame_trk
  import sample_rx_pkg::*;
#(
  parameter int unsigned WORD_W     = 12,
  parameter int unsigned LOCK_EDGES = 4,
  parameter int unsigned TIMEOUT    = 24,
  localparam int unsigned CNT_W     = $clog2(TIMEOUT + 1),
  localparam int unsigned GOOD_W    = $clog2(LOCK_EDGES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic msb_o,
  output logic done_o,
  output logic locked_o,
  output logic align_err_o
);
  trk_state_e        state_q;
  logic              frame_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GOOD_W-1:0] good_q;
  logic              locked_q, err_q;
  logic              msb, running, spacing_ok, done, timeout;

  assign msb        = frame_i & ~frame_q;  // R1
  assign running    = (state_q == TRK_RUN);
  assign spacing_ok = (cnt_q == CNT_W'(WORD_W));
  assign done       = running & ~msb & (cnt_q == CNT_W'(WORD_W - 1));
  assign timeout    = running & ~msb & (cnt_q == CNT_W'(TIMEOUT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TRK_IDLE;
      frame_q  <= 1'b0;
      cnt_q    <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      frame_q <= frame_i;
      err_q   <= 1'b0;
      if (msb) begin
        state_q <= TRK_RUN;
        cnt_q   <= CNT_W'(1);
        if (running && !spacing_ok) begin
          // R5: misplaced edge
          err_q    <= 1'b1;
          locked_q <= 1'b0;
          good_q   <= '0;
        end else if (running) begin
          // R6: count good edges
          if (good_q != GOOD_W'(LOCK_EDGES)) good_q <= good_q + GOOD_W'(1);
          if (good_q == GOOD_W'(LOCK_EDGES - 1)) locked_q <= 1'b1;
        end else begin
          good_q <= '0;
        end
      end else if (timeout) begin
        // R7: frame line silent
        state_q  <= TRK_IDLE;
        locked_q <= 1'b0;
        good_q   <= '0;
      end else if (running) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign msb_o       = msb;
  assign done_o      = done;
  assign locked_o    = locked_q;
  assign align_err_o = err_q;
endmodule

// File: rtl/sample_rx_shifter.sv
module sample_rx_shifter #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              msb_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (msb_i) sh_q <= {{(WORD_W - 2){1'b0}}, bit_i};
    else            sh_q <= {sh_q[WORD_W-3:0], bit_i};
  end

  // complete word in the cycle its last bit is on the lane
  assign word_o = {sh_q, bit_i};
endmodule

// File: rtl/sample_rx_fmt.sv
module sample_rx_fmt #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              tcomp_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  // R4: offset binary to two's complement
  assign word_o = {word_i[WORD_W-1] ^ tcomp_i, word_i[WORD_W-2:0]};
endmodule

// File: rtl/sample_rx.sv
module sample_rx
  import sample_rx_pkg::*;
#(
  parameter int unsigned LANES      = LANES_DEF,
  parameter int unsigned WORD_W     = WORD_W_DEF,
  parameter int unsigned LOCK_EDGES = 4,
  parameter int unsigned TIMEOUT    = 24,
  localparam int unsigned DATA_W    = LANES * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  lane_i,
  input  logic              frame_i,
  input  logic              tcomp_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              locked_o,
  output logic              align_err_o
);
  logic              msb, done, locked;
  logic [DATA_W-1:0] next_data;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  sample_rx_frame_trk #(
    .WORD_W    (WORD_W),
    .LOCK_EDGES(LOCK_EDGES),
    .TIMEOUT   (TIMEOUT)
  ) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .msb_o      (msb),
    .done_o     (done),
    .locked_o   (locked),
    .align_err_o(align_err_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] cap, fmt;

    sample_rx_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .bit_i (lane_i[l]),
      .msb_i (msb),
      .word_o(cap)
    );

    sample_rx_fmt #(.WORD_W(WORD_W)) u_fmt (
      .tcomp_i(tcomp_i),
      .word_i (cap),
      .word_o (fmt)
    );

    assign next_data[l*WORD_W +: WORD_W] = fmt;
  end

  // R2, R3, R8: all lanes together, only while locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= done & locked;
      if (done && locked) data_q <= next_data;
    end
  end

  assign data_o   = data_q;
  assign valid_o  = valid_q;
  assign locked_o = locked;
endmodule

// File: rtl/sample_rx_chk.sv
module sample_rx_chk #(
  parameter int unsigned DATA_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              locked_o,
  input logic              align_err_o
);
  // R8
  valid_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_o);

  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // R5
  err_unlocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> !locked_o);

  // R5
  err_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> !align_err_o);

  // R6
  lock_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> ($past(frame_i) && !$past(frame_i, 2)));
endmodule

bind sample_rx sample_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .data_o     (data_o),
  .valid_o    (valid_o),
  .locked_o   (locked_o),
  .align_err_o(align_err_o)
);

// File: tb/sample_rx_tb.sv
module sample_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 4;
  localparam int WORD_W     = 12;
  localparam int DATA_W     = LANES * WORD_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [LANES-1:0]  lane_i = '0;
  logic              frame_i = 1'b0;
  logic              tcomp_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic              valid_o, locked_o, align_err_o;

  int                n_vec = 0;
  int                n_bad = 0;
  int                n_err_seen = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sample_rx u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lane_i     (lane_i),
    .frame_i    (frame_i),
    .tcomp_i    (tcomp_i),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .locked_o   (locked_o),
    .align_err_o(align_err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic logic [DATA_W-1:0] fmt(input logic [DATA_W-1:0] raw, input bit tc);
    logic [DATA_W-1:0] r = raw;
    for (int l = 0; l < LANES; l++) r[l*WORD_W + WORD_W-1] = raw[l*WORD_W + WORD_W-1] ^ tc;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] gen(input int k);
    logic [DATA_W-1:0] r;
    for (int l = 0; l < LANES; l++)
      r[l*WORD_W +: WORD_W] = WORD_W'(k * 'h2B7 + l * 'h4C1 + 'h0A5);
    return r;
  endfunction

  // driver: one word of nbits, frame high at its first bit (R1)
  task automatic send_word(input logic [DATA_W-1:0] raw, input int nbits, input bit tc, input bit exp_v);
    int hi = (nbits < WORD_W) ? 3 : 6;
    if (exp_v) exp_q.push_back(fmt(raw, tc));
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk_i);
      if (b == 0) tcomp_i = tc;
      frame_i = (b < hi);
      for (int l = 0; l < LANES; l++)
        lane_i[l] = (b < WORD_W) ? raw[l*WORD_W + WORD_W-1-b] : 1'b0;
    end
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      frame_i = 1'b0;
      lane_i  = '0;
    end
  endtask

  // reference edge + 3 good edges unlocked, 5th edge locks (R6, R8)
  task automatic lock_train(input int base);
    for (int k = 0; k < 4; k++) send_word(gen(base + k), WORD_W, 1'b0, 1'b0);
    chk(locked_o == 1'b0, "R6 unlocked before 5th edge", 64'(locked_o), 64'h0);
    send_word(gen(base + 4), WORD_W, 1'b0, 1'b1);
    chk(locked_o == 1'b1, "R6 locked at 5th edge", 64'(locked_o), 64'h1);
  endtask

  // monitor / scoreboard
  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (align_err_o) n_err_seen++;
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected valid", 64'(data_o), 64'h0);
        end else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          chk(data_o == e, "R2 word", 64'(data_o), 64'(e));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk({data_o, valid_o, locked_o, align_err_o} == '0, "R9 reset outputs",
        64'({valid_o, locked_o, align_err_o}), 64'h0);
    rst_ni = 1'b1;
    send_idle(2);

    // R1 R2 R6 R8: initial lock, then plain words
    lock_train(0);
    send_word({DATA_W{1'b0}}, WORD_W, 1'b0, 1'b1);
    send_word({DATA_W{1'b1}}, WORD_W, 1'b0, 1'b1);
    send_word(gen(20), WORD_W, 1'b0, 1'b1);

    // R4: two's complement mode on boundary codes
    send_word({4{12'h800}}, WORD_W, 1'b1, 1'b1);
    send_word({12'h7FF, 12'h000, 12'hFFF, 12'h801}, WORD_W, 1'b1, 1'b1);
    send_word(gen(21), WORD_W, 1'b1, 1'b1);
    send_word({12'h7FF, 12'h000, 12'hFFF, 12'h801}, WORD_W, 1'b0, 1'b1);
    chk(n_err_seen == 0, "R5 no error on good spacing", 64'(n_err_seen), 64'h0);

    // R5: short word (7 bits), partial word discarded
    send_word(gen(30), 7, 1'b0, 1'b0);
    send_word(gen(31), WORD_W, 1'b0, 1'b0);
    chk(n_err_seen == 1, "R5 error on short spacing", 64'(n_err_seen), 64'h1);
    chk(locked_o == 1'b0, "R5 unlock on short spacing", 64'(locked_o), 64'h0);
    // edge of gen(31) was the reference; 3 more unlocked, then lock
    for (int k = 0; k < 3; k++) send_word(gen(32 + k), WORD_W, 1'b0, 1'b0);
    chk(locked_o == 1'b0, "R6 unlocked after error train", 64'(locked_o), 64'h0);
    send_word(gen(35), WORD_W, 1'b0, 1'b1);
    chk(locked_o == 1'b1, "R6 relock after error", 64'(locked_o), 64'h1);

    // R8: long word (14 bits) while locked still delivers first 12 bits
    send_word(gen(40), 14, 1'b0, 1'b1);
    send_word(gen(41), WORD_W, 1'b0, 1'b0);
    chk(n_err_seen == 2, "R5 error on long spacing", 64'(n_err_seen), 64'h2);
    chk(locked_o == 1'b0, "R5 unlock on long spacing", 64'(locked_o), 64'h0);
    for (int k = 0; k < 3; k++) send_word(gen(42 + k), WORD_W, 1'b0, 1'b0);
    send_word(gen(45), WORD_W, 1'b0, 1'b1);
    chk(locked_o == 1'b1, "R6 relock after long", 64'(locked_o), 64'h1);

    // R7: timeout after 24 edge-free bits
    send_idle(13);
    chk(locked_o == 1'b1, "R7 still locked at 23 idle bits", 64'(locked_o), 64'h1);
    send_idle(1);
    chk(locked_o == 1'b0, "R7 unlock at 24 idle bits", 64'(locked_o), 64'h0);
    chk(n_err_seen == 2, "R7 timeout raises no error", 64'(n_err_seen), 64'h2);
    lock_train(50);
    chk(n_err_seen == 2, "R7 reference edge after timeout", 64'(n_err_seen), 64'h2);

    send_idle(3);
    chk(exp_q.size() == 0, "R2 all expected words seen", 64'(exp_q.size()), 64'h0);
    summary();
  end
endmodule